// File: doc/BRIEF.md
# Cascadable Eight-Level Priority Interrupt Controller

The block watches eight interrupt request lines and picks the most urgent one that is active, with line 7 the most urgent and line 0 the least. Software holds a 3-bit current-status level together with a compare-select flag. When comparison is selected, a request raises an interrupt only if its level number is strictly greater than the held status level. When comparison is not selected, the held level is ignored and any request raises an interrupt. A fired interrupt drives an active-low registered output for one cycle and latches the 3-bit number of the winning level. A read-enable input gates that number onto the vector outputs.

Several units can be chained in priority order. Each unit takes a group-enable input and drives a next-group enable output. That output stays low while the unit is disabled or sees any request, so a lower group can only interrupt when every group above it is idle. Each interrupt uses up the unit's arm state, and the unit has to be re-enabled before it can issue the next one.

Top module: `pic8_cascade`

## Requirements
- R1: While `rst` is high and after it falls, `irq_n` is 1 and `vec_o` is 0. The status level resets to 0 with comparison selected.
- R2: On a rising clock edge with `stat_ld_i` high, the status level takes `stat_i` and the compare flag takes `cmp_sel_i`. Otherwise both hold. A request sampled on the load edge is compared against the value held before the load.
- R3: Request bit `req_i[k]` stands for level k, and a higher k wins. The winning level is the index of the highest set bit.
- R4: With comparison selected, an armed and enabled unit fires only when the winning level is strictly greater than the status level.
- R5: With comparison deselected (`cmp_sel_i` loaded as 0), any active request fires an armed and enabled unit, at any status value.
- R6: No interrupt fires on an edge where `grp_en_i` is low.
- R7: `ien_i` high at an edge arms the unit. A firing edge disarms it, and the disarm wins over a simultaneous `ien_i`. A disarmed unit never fires, so `irq_n` is never low on two consecutive cycles.
- R8: `irq_n` goes low in the cycle right after the edge at which the fire condition held, and it is high otherwise.
- R9: The winning level is latched at each firing edge and held until the next one. `vec_o` shows the latched level while `rd_en_i` is high and shows 0 while it is low.
- R10: `nxt_en_o` is high exactly when `grp_en_i` is high and no bit of `req_i` is set. It follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, bit 7 most urgent |
| stat_i | input | 3 | Status level to load |
| cmp_sel_i | input | 1 | Compare flag to load (1 = compare against status) |
| stat_ld_i | input | 1 | Status load strobe |
| ien_i | input | 1 | Interrupt enable (arms the unit) |
| rd_en_i | input | 1 | Gates the latched vector onto `vec_o` |
| grp_en_i | input | 1 | Enable from the next higher group |
| nxt_en_o | output | 1 | Enable passed to the next lower group |
| irq_n | output | 1 | Registered interrupt, active low |
| vec_o | output | 3 | Latched winning level, zero when not read |

## Verification
The arm state cannot be seen at the ports. The hardest case is therefore a firing edge where `ien_i` is also high, because the disarm has to beat the re-arm on that edge. The stimulus holds `ien_i` high across a run of requests and expects `irq_n` to alternate low and high on successive cycles rather than stay low. The stimulus also loads a new status on the same edge as a request, so that the comparison has to use the old level.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned N_LVL_DEF = 8;
  localparam int unsigned LVL_W_DEF = $clog2(N_LVL_DEF);
  localparam int unsigned VEC_IDLE  = 0;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N_LVL = pic_pkg::N_LVL_DEF,
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] req,
  output logic             any,
  output logic [LVL_W-1:0] win
);
  logic [N_LVL-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < N_LVL; g++) begin : g_mask
      if (g == N_LVL - 1) begin : g_top
        assign hit_vec[g] = req[g];
      end else begin : g_low
        assign hit_vec[g] = req[g] & ~(|req[N_LVL-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (hit_vec[i]) win = i[LVL_W-1:0];
    end
  end

  assign any = |req;
endmodule

// File: rtl/pic_status_reg.sv
module pic_status_reg #(
  parameter int unsigned LVL_W = pic_pkg::LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             cmp_in,
  output logic [LVL_W-1:0] lvl_q,
  output logic             cmp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      cmp_q <= 1'b1;
    end else if (ld) begin
      lvl_q <= lvl_in;
      cmp_q <= cmp_in;
    end
  end
endmodule

// File: rtl/pic_irq_ctl.sv
module pic_irq_ctl #(
  parameter int unsigned LVL_W = pic_pkg::LVL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any,
  input  logic [LVL_W-1:0] win,
  input  logic [LVL_W-1:0] stat_lvl,
  input  logic             stat_cmp,
  input  logic             ien,
  input  logic             grp_en,
  output logic             arm_q,
  output logic             irq_q,
  output logic [LVL_W-1:0] vec_q
);
  logic outranks;
  logic fire;

  assign outranks = any & (~stat_cmp | (win > stat_lvl));
  assign fire     = arm_q & grp_en & outranks;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      irq_q <= 1'b0;
      vec_q <= LVL_W'(pic_pkg::VEC_IDLE);
    end else begin
      irq_q <= fire;
      if (fire) begin
        arm_q <= 1'b0;
        vec_q <= win;
      end else if (ien) begin
        arm_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic8_cascade.sv
module pic8_cascade #(
  parameter int unsigned N_LVL = pic_pkg::N_LVL_DEF,
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] req_i,
  input  logic [LVL_W-1:0] stat_i,
  input  logic             cmp_sel_i,
  input  logic             stat_ld_i,
  input  logic             ien_i,
  input  logic             rd_en_i,
  input  logic             grp_en_i,
  output logic             nxt_en_o,
  output logic             irq_n,
  output logic [LVL_W-1:0] vec_o
);
  logic             any_req;
  logic [LVL_W-1:0] win_lvl;
  logic [LVL_W-1:0] stat_lvl_q;
  logic             stat_cmp_q;
  logic             arm_q;
  logic             irq_q;
  logic [LVL_W-1:0] vec_q;

  pic_prio_enc #(.N_LVL(N_LVL)) u_enc (
    .req (req_i),
    .any (any_req),
    .win (win_lvl)
  );

  pic_status_reg #(.LVL_W(LVL_W)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .ld     (stat_ld_i),
    .lvl_in (stat_i),
    .cmp_in (cmp_sel_i),
    .lvl_q  (stat_lvl_q),
    .cmp_q  (stat_cmp_q)
  );

  pic_irq_ctl #(.LVL_W(LVL_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .any      (any_req),
    .win      (win_lvl),
    .stat_lvl (stat_lvl_q),
    .stat_cmp (stat_cmp_q),
    .ien      (ien_i),
    .grp_en   (grp_en_i),
    .arm_q    (arm_q),
    .irq_q    (irq_q),
    .vec_q    (vec_q)
  );

  assign nxt_en_o = grp_en_i & ~any_req;
  assign irq_n    = ~irq_q;
  assign vec_o    = rd_en_i ? vec_q : '0;
endmodule

// File: rtl/pic8_cascade_chk.sv
module pic8_cascade_chk #(
  parameter int unsigned N_LVL = pic_pkg::N_LVL_DEF,
  localparam int unsigned LVL_W = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst,
  input logic [N_LVL-1:0] req_i,
  input logic             stat_ld_i,
  input logic             rd_en_i,
  input logic             grp_en_i,
  input logic             irq_n,
  input logic [LVL_W-1:0] vec_o,
  input logic [LVL_W-1:0] stat_lvl_q
);
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    !irq_n |=> irq_n);

  a_r6_needs_group_enable: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(grp_en_i));

  a_r8_needs_request: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|req_i));

  a_r9_vector_held: assert property (@(posedge clk) disable iff (rst)
    (irq_n && rd_en_i && $past(rd_en_i) && !$past(rst)) |-> $stable(vec_o));

  a_r2_status_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_ld_i) && !$past(rst)) |-> $stable(stat_lvl_q));
endmodule

bind pic8_cascade pic8_cascade_chk #(.N_LVL(N_LVL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .stat_ld_i  (stat_ld_i),
  .rd_en_i    (rd_en_i),
  .grp_en_i   (grp_en_i),
  .irq_n      (irq_n),
  .vec_o      (vec_o),
  .stat_lvl_q (stat_lvl_q)
);

// File: tb/pic8_cascade_test.sv
module pic8_cascade_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_i = '0;
  logic [2:0] stat_i = '0;
  logic       cmp_sel_i = 1'b1;
  logic       stat_ld_i = 1'b0;
  logic       ien_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic       grp_en_i = 1'b0;
  logic       nxt_en_o;
  logic       irq_n;
  logic [2:0] vec_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit         irq_n;
    logic [2:0] vec;
    string      tag;
  } exp_t;
  exp_t q[$];

  // bench model state, from the requirements
  logic [2:0] m_lvl = 3'd0;
  bit         m_cmp = 1;
  bit         m_arm = 0;
  logic [2:0] m_vec = 3'd0;

  always #10 clk = ~clk;

  pic8_cascade uut (
    .clk(clk), .rst(rst), .req_i(req_i), .stat_i(stat_i),
    .cmp_sel_i(cmp_sel_i), .stat_ld_i(stat_ld_i), .ien_i(ien_i),
    .rd_en_i(rd_en_i), .grp_en_i(grp_en_i), .nxt_en_o(nxt_en_o),
    .irq_n(irq_n), .vec_o(vec_o)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [7:0] rq, bit ie, bit ge, bit rd,
                      bit ld, logic [2:0] st, bit cs, string tag);
    exp_t e;
    int   w;
    bit   fire;
    @(negedge clk);
    req_i = rq; ien_i = ie; grp_en_i = ge; rd_en_i = rd;
    stat_ld_i = ld; stat_i = st; cmp_sel_i = cs;
    w = 0;
    for (int i = 0; i < 8; i++) if (rq[i]) w = i;
    fire = m_arm && ge && (rq != 0) && (!m_cmp || (w > int'(m_lvl)));
    if (fire) begin
      m_arm = 0;
      m_vec = w[2:0];
    end else if (ie) begin
      m_arm = 1;
    end
    if (ld) begin
      m_lvl = st;
      m_cmp = cs;
    end
    e.irq_n = !fire;
    e.vec   = rd ? m_vec : 3'd0;
    e.tag   = tag;
    q.push_back(e);
    #1;
    check({"R10 nxt_en ", tag}, int'(nxt_en_o), int'(ge && rq == 0));
  endtask

  // monitor: compare registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " irq_n"}, int'(irq_n), int'(e.irq_n));
        check({e.tag, " vec"}, int'(vec_o), int'(e.vec));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset irq_n", int'(irq_n), 1);
    rd_en_i = 1'b1;
    #1;
    check("R1 reset vec", int'(vec_o), 0);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset status 0 with compare on, so level 0 must not fire
    step(8'h00, 1, 1, 1, 0, 3'd0, 1, "R7 arm");
    step(8'h01, 0, 1, 1, 0, 3'd0, 1, "R1 lvl0 vs reset status");
    // R2: load status 2, compare on
    step(8'h00, 0, 1, 1, 1, 3'd2, 1, "R2 load");
    step(8'h04, 0, 1, 1, 0, 3'd0, 1, "R4 equal no fire");
    step(8'h08, 0, 1, 1, 0, 3'd0, 1, "R4 above fires");
    step(8'h08, 0, 1, 1, 0, 3'd0, 1, "R7 disarmed");
    step(8'h08, 0, 1, 0, 0, 3'd0, 1, "R9 read gate off");
    step(8'h00, 0, 1, 1, 0, 3'd0, 1, "R9 held");
    // R3: highest bit wins
    step(8'h00, 1, 1, 1, 0, 3'd0, 1, "R7 rearm");
    step(8'h92, 0, 1, 1, 0, 3'd0, 1, "R3 win 7");
    step(8'h00, 1, 1, 1, 0, 3'd0, 1, "R7 rearm2");
    step(8'h36, 0, 1, 1, 0, 3'd0, 1, "R3 win 5");
    // R6: group disabled blocks
    step(8'h00, 1, 0, 1, 0, 3'd0, 1, "R6 arm");
    step(8'h40, 0, 0, 1, 0, 3'd0, 1, "R6 blocked");
    step(8'h00, 0, 0, 1, 0, 3'd0, 1, "R10 disabled idle");
    step(8'h40, 0, 1, 1, 0, 3'd0, 1, "R6 enabled fires");
    // R5: compare off, status 7, level 0 fires
    step(8'h00, 1, 1, 1, 1, 3'd7, 0, "R5 load off");
    step(8'h01, 0, 1, 1, 0, 3'd0, 1, "R5 lvl0 fires");
    // R7: ien held high with request present
    step(8'h02, 1, 1, 1, 0, 3'd0, 1, "R7 hold a");
    step(8'h02, 1, 1, 1, 0, 3'd0, 1, "R7 hold b");
    step(8'h02, 1, 1, 1, 0, 3'd0, 1, "R7 hold c");
    step(8'h02, 1, 1, 1, 0, 3'd0, 1, "R7 hold d");
    // R2: load same edge as request uses old status (compare off)
    step(8'h00, 1, 1, 1, 0, 3'd0, 1, "R7 arm3");
    step(8'h04, 0, 1, 1, 1, 3'd6, 1, "R2 old status used");
    step(8'h00, 1, 1, 1, 0, 3'd0, 1, "R7 arm4");
    step(8'h20, 0, 1, 1, 0, 3'd0, 1, "R2 new status blocks");
    step(8'h80, 0, 1, 1, 0, 3'd0, 1, "R4 lvl7 above 6");
    step(8'h00, 0, 1, 1, 0, 3'd0, 1, "R8 idle");
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule